// File: doc/BRIEF.md
# Descriptor-Driven Display Byte Transmitter

This block feeds a display link from a word-wide transmit queue. Software, or a DMA engine, writes 32-bit words into an internal FIFO. The first word of each transfer is a packed descriptor. The words after it carry payload bytes, four per word. The engine decodes the descriptor and can hold off until an edge on the panel's tearing signal. It then emits the payload as a byte stream over a valid/ready handshake, with a data/command flag that stays constant for the whole transfer.

While the bytes stream out, the engine can reverse byte order inside each pixel unit of two or four bytes, as the descriptor's unit format and a global endian input select. Status outputs report the FIFO fill level, a low-water threshold, a sticky overflow and a sticky transfer-complete flag. Clearing the enable input empties the queue and aborts any transfer in progress.

Top module: `lcd_xfer_engine`

## Requirements
- R1: Descriptor bits 17:0 hold the byte count minus one, and exactly that many bytes plus one are emitted. Bit 30 selects command (0) or data (1), and `out_dc` equals that bit on every byte of the transfer.
- R2: Each payload word carries four stream bytes, the earliest byte in bits 7:0. A final partial word carries the 1 to 3 remaining bytes in its low lanes.
- R3: Descriptor bits 28:27 give the unit size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, and 3 is treated as 1 byte. With `swap_en`=1 the byte order inside every complete unit is reversed. With `swap_en`=0, or with 1-byte units, the order is natural.
- R4: Trailing bytes that do not fill a whole unit at the end of a transfer are emitted in natural order.
- R5: Descriptor bits 25:24 select tearing sync: 0 and 3 mean no wait, 1 waits for a rising edge of `te_in`, and 2 waits for a falling edge. The edge must occur after the descriptor is taken. The opposite edge does not start the transfer.
- R6: Descriptor bits 31, 29, 26, 23, 22:21 and 20:18 have no effect on the output.
- R7: A write while `fifo_level` equals the FIFO depth is dropped and sets `ovf_sts`. The flag stays set until `ovf_clr` is pulsed, and a new overflow wins over a clear in the same cycle.
- R8: `thresh_sts` is 1 exactly when `fifo_level` is at or below `thresh_lvl`.
- R9: `done_sts` sets in the cycle after the last byte of a transfer is accepted. It stays set until `done_clr` is pulsed.
- R10: While `out_valid` is high and `out_ready` is low, `out_byte` holds its value and `out_valid` stays high.
- R11: With `enable` low, the FIFO is emptied, the engine idles, `out_valid` stays low and writes are ignored. The sticky flags keep their values, and the engine restarts cleanly on a new descriptor.
- R12: The word after a transfer's last payload word is the next descriptor. Unused lanes of a final partial word are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable; low flushes and idles |
| swap_en | input | 1 | 1 reverses bytes within each pixel unit |
| thresh_lvl | input | LVL_W | FIFO low-water threshold |
| wr_valid | input | 1 | FIFO write strobe |
| wr_data | input | 32 | FIFO write word (descriptor or payload) |
| ovf_clr | input | 1 | Clears the overflow flag |
| done_clr | input | 1 | Clears the transfer-done flag |
| te_in | input | 1 | Tearing signal from the panel (asynchronous) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_byte | output | 8 | Output byte |
| out_dc | output | 1 | Data (1) / command (0) flag |
| busy | output | 1 | A transfer is in progress |
| fifo_level | output | LVL_W | Words held in the FIFO |
| thresh_sts | output | 1 | Level at or below threshold |
| ovf_sts | output | 1 | Sticky overflow flag |
| done_sts | output | 1 | Sticky transfer-done flag |

## Verification
The hardest state to reach from the ports is a full FIFO with the overflow flag set. The engine drains words as fast as they arrive, so the queue never fills on its own. The bench starts a long transfer and then holds `out_ready` low, so the engine stalls in its send state after taking the descriptor and one payload word. Writes then fill the queue one word at a time, which steps the threshold boundary and reaches the overflow point. The tearing wait is reached in a similar way: the whole transfer is queued while `te_in` stays quiet, and the opposite edge is driven before the edge that releases it.

// File: rtl/lcdx_pkg.sv
package lcdx_pkg;

  localparam int LEN_FIELD_W = 18;
  localparam int BYTE_CNT_W  = LEN_FIELD_W + 1;

  typedef enum logic [1:0] {
    UNIT_B1   = 2'd0,
    UNIT_B2   = 2'd1,
    UNIT_B4   = 2'd2,
    UNIT_RSVD = 2'd3
  } unit_fmt_e;

  typedef enum logic [1:0] {
    TE_OFF  = 2'd0,
    TE_RISE = 2'd1,
    TE_FALL = 2'd2,
    TE_RSVD = 2'd3
  } te_mode_e;

  // Packed descriptor, MSB first; positions follow the word written by software
  typedef struct packed {
    logic                   dir_tx;
    logic                   is_data;
    logic                   irq_en;
    unit_fmt_e              unit_fmt;
    logic                   tmo_mode;
    te_mode_e               te_mode;
    logic                   repeat_en;
    logic [1:0]             spare;
    logic [2:0]             gap_cycles;
    logic [LEN_FIELD_W-1:0] len_m1;
  } xfer_desc_t;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_TE    = 2'd1,
    ENG_FETCH = 2'd2,
    ENG_SEND  = 2'd3
  } eng_state_e;

endpackage

// File: rtl/lcdx_fifo.sv
module lcdx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level_q == LVL_W'(DEPTH));
  assign empty   = (level_q == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;
  assign level   = level_q;
  assign rdata   = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      if (push_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr_q);
      level_d = level_q + LVL_W'(push_ok) - LVL_W'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= wdata;
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVL_W'(DEPTH)) else $error("fifo level above depth"); // R7

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (level_q == LVL_W'(DEPTH)))
    else $error("write to full fifo changed level"); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty) else $error("flush left words behind"); // R11

endmodule

// File: rtl/lcdx_te_gate.sv
module lcdx_te_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic te_in,
  output logic te_rise,
  output logic te_fall
);

  // [0],[1]: synchronizer stages, [2]: previous synchronized value
  logic [2:0] te_q, te_d;

  always_comb begin
    te_d = {te_q[1:0], te_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) te_q <= '0;
    else        te_q <= te_d;
  end

  assign te_rise = te_q[1] & ~te_q[2];
  assign te_fall = ~te_q[1] & te_q[2];

endmodule

// File: rtl/lcdx_lane_sel.sv
module lcdx_lane_sel
  import lcdx_pkg::*;
#(
  parameter int CNT_W = BYTE_CNT_W
) (
  input  logic [31:0]      word,
  input  logic [1:0]       idx,
  input  unit_fmt_e        unit_fmt,
  input  logic             swap_en,
  input  logic [CNT_W-1:0] remain,
  output logic [7:0]       byte_out
);

  logic [1:0]     unit_mask;
  logic [1:0]     lane;
  logic [CNT_W:0] unit_left;
  logic           unit_whole;

  always_comb begin
    case (unit_fmt)
      UNIT_B2: unit_mask = 2'b01;
      UNIT_B4: unit_mask = 2'b11;
      default: unit_mask = 2'b00;
    endcase
    // bytes left counted from the first byte of the current unit
    unit_left  = {1'b0, remain} + (CNT_W + 1)'(idx & unit_mask);
    unit_whole = unit_left > (CNT_W + 1)'(unit_mask);
    lane       = (swap_en && unit_whole) ? (idx ^ unit_mask) : idx;
    byte_out   = word[8*lane +: 8];
  end

endmodule

// File: rtl/lcd_xfer_engine.sv
module lcd_xfer_engine
  import lcdx_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             swap_en,
  input  logic [LVL_W-1:0] thresh_lvl,
  input  logic             wr_valid,
  input  logic [31:0]      wr_data,
  input  logic             ovf_clr,
  input  logic             done_clr,
  input  logic             te_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_byte,
  output logic             out_dc,
  output logic             busy,
  output logic [LVL_W-1:0] fifo_level,
  output logic             thresh_sts,
  output logic             ovf_sts,
  output logic             done_sts
);

  localparam int CNT_W = BYTE_CNT_W;

  eng_state_e       state_q, state_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic [31:0]      word_q, word_d;
  logic [1:0]       idx_q, idx_d;
  logic             dc_q, dc_d;
  unit_fmt_e        fmt_q, fmt_d;
  te_mode_e         te_q, te_d;
  logic             done_q, done_d;
  logic             ovf_q, ovf_d;

  logic             fifo_pop, fifo_full, fifo_empty;
  logic [31:0]      fifo_rdata;
  logic             te_rise, te_fall;
  logic             handshake, last_byte;
  xfer_desc_t       desc;

  lcdx_fifo #(
    .WIDTH (32),
    .DEPTH (FIFO_DEPTH),
    .LVL_W (LVL_W)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (~enable),
    .push  (wr_valid & enable),
    .wdata (wr_data),
    .pop   (fifo_pop),
    .rdata (fifo_rdata),
    .level (fifo_level),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  lcdx_te_gate u_te (
    .clk     (clk),
    .rst_n   (rst_n),
    .te_in   (te_in),
    .te_rise (te_rise),
    .te_fall (te_fall)
  );

  lcdx_lane_sel #(
    .CNT_W (CNT_W)
  ) u_lane (
    .word     (word_q),
    .idx      (idx_q),
    .unit_fmt (fmt_q),
    .swap_en  (swap_en),
    .remain   (remain_q),
    .byte_out (out_byte)
  );

  assign desc       = xfer_desc_t'(fifo_rdata);
  assign out_valid  = (state_q == ENG_SEND) && enable;
  assign handshake  = out_valid && out_ready;
  assign last_byte  = (remain_q == CNT_W'(1));
  assign out_dc     = dc_q;
  assign busy       = (state_q != ENG_IDLE);
  assign thresh_sts = (fifo_level <= thresh_lvl);
  assign ovf_sts    = ovf_q;
  assign done_sts   = done_q;

  // Next-state logic of the transfer engine
  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    word_d   = word_q;
    idx_d    = idx_q;
    dc_d     = dc_q;
    fmt_d    = fmt_q;
    te_d     = te_q;
    fifo_pop = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (!fifo_empty) begin
          fifo_pop = 1'b1;
          remain_d = CNT_W'(desc.len_m1) + CNT_W'(1);
          dc_d     = desc.is_data;
          fmt_d    = desc.unit_fmt;
          te_d     = desc.te_mode;
          state_d  = (desc.te_mode == TE_RISE || desc.te_mode == TE_FALL)
                     ? ENG_TE : ENG_FETCH;
        end
      end
      ENG_TE: begin
        if ((te_q == TE_RISE && te_rise) || (te_q == TE_FALL && te_fall))
          state_d = ENG_FETCH;
      end
      ENG_FETCH: begin
        if (!fifo_empty) begin
          fifo_pop = 1'b1;
          word_d   = fifo_rdata;
          idx_d    = 2'd0;
          state_d  = ENG_SEND;
        end
      end
      ENG_SEND: begin
        if (handshake) begin
          remain_d = remain_q - CNT_W'(1);
          idx_d    = idx_q + 2'd1;
          if (last_byte)          state_d = ENG_IDLE;
          else if (idx_q == 2'd3) state_d = ENG_FETCH;
        end
      end
      default: state_d = ENG_IDLE;
    endcase
    if (!enable) begin
      state_d  = ENG_IDLE;
      fifo_pop = 1'b0;
    end
  end

  // Sticky status next-state: a new event wins over a clear
  always_comb begin
    done_d = done_q;
    if (done_clr) done_d = 1'b0;
    if (handshake && last_byte) done_d = 1'b1;
    ovf_d = ovf_q;
    if (ovf_clr) ovf_d = 1'b0;
    if (wr_valid && enable && fifo_full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ENG_IDLE;
      remain_q <= '0;
      word_q   <= '0;
      idx_q    <= '0;
      dc_q     <= 1'b0;
      fmt_q    <= UNIT_B1;
      te_q     <= TE_OFF;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
      word_q   <= word_d;
      idx_q    <= idx_d;
      dc_q     <= dc_d;
      fmt_q    <= fmt_d;
      te_q     <= te_d;
      done_q   <= done_d;
      ovf_q    <= ovf_d;
    end
  end

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_byte) && (out_valid || !enable)))
    else $error("byte changed while stalled"); // R10

  AST_DC_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(out_dc)))
    else $error("dc flag moved inside a transfer"); // R1

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_sts && !done_clr) |=> done_sts)
    else $error("done flag dropped without clear"); // R9

  AST_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_sts) |-> $past(out_valid && out_ready))
    else $error("done flag set without a final byte"); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sts && !ovf_clr) |=> ovf_sts)
    else $error("overflow flag dropped without clear"); // R7

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!out_valid && fifo_level == '0))
    else $error("engine active while disabled"); // R11

endmodule

// File: tb/lcd_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module lcd_xfer_engine_tb_top;

  localparam int DEPTH = 8;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             enable, swap_en, wr_valid, ovf_clr, done_clr, te_in, out_ready;
  logic [LVL_W-1:0] thresh_lvl;
  logic [31:0]      wr_data;
  logic             out_valid, out_dc, busy, thresh_sts, ovf_sts, done_sts;
  logic [7:0]       out_byte;
  logic [LVL_W-1:0] fifo_level;

  int n_tests = 0;
  int n_fail  = 0;
  int bp_mode = 0;
  int cyc     = 0;
  int cap_n   = 0;
  logic [7:0] cap_b  [0:2047];
  logic       cap_dc [0:2047];

  always #2 clk = ~clk;

  lcd_xfer_engine #(.FIFO_DEPTH(DEPTH), .LVL_W(LVL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .swap_en(swap_en),
    .thresh_lvl(thresh_lvl), .wr_valid(wr_valid), .wr_data(wr_data),
    .ovf_clr(ovf_clr), .done_clr(done_clr), .te_in(te_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_dc(out_dc), .busy(busy), .fifo_level(fifo_level),
    .thresh_sts(thresh_sts), .ovf_sts(ovf_sts), .done_sts(done_sts)
  );

  // Downstream sink: set ready, then log the byte taken at the next edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    case (bp_mode)
      1:       out_ready = ((cyc % 3) != 0);
      2:       out_ready = 1'b0;
      default: out_ready = 1'b1;
    endcase
    if (out_valid && out_ready && cap_n < 2048) begin
      cap_b[cap_n]  = out_byte;
      cap_dc[cap_n] = out_dc;
      cap_n = cap_n + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail = n_fail + 1;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests = n_tests + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int seed, input int i);
    return 8'((i * 29) + (seed * 7) + 3);
  endfunction

  function automatic logic [7:0] exp_byte(input int seed, input int n, input int fmt,
                                          input logic sw, input int p);
    int u;
    int us;
    u = (fmt == 1) ? 2 : (fmt == 2) ? 4 : 1;
    us = p - (p % u);
    if (sw && u > 1 && (us + u) <= n) return pbyte(seed, us + (u - 1 - (p % u)));
    return pbyte(seed, p);
  endfunction

  function automatic logic [31:0] mk_desc(input int n, input logic dc, input int fmt,
                                          input int te, input logic [31:0] extra);
    return extra | (32'(dc) << 30) | (32'(fmt) << 27) | (32'(te) << 24) | 32'(n - 1);
  endfunction

  task automatic push_word(input logic [31:0] d);
    @(negedge clk);
    while (fifo_level >= LVL_W'(DEPTH)) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic raw_write(input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic load_xfer(input int seed, input int n, input logic [31:0] desc);
    push_word(desc);
    for (int k = 0; k < (n + 3) / 4; k++) begin
      logic [31:0] w;
      for (int j = 0; j < 4; j++)
        w[8*j +: 8] = (4*k + j < n) ? pbyte(seed, 4*k + j) : 8'hEE;
      push_word(w);
    end
  endtask

  task automatic compare(input string req, input int base, input int seed, input int n,
                         input logic dc, input int fmt, input logic sw);
    int mism;
    int bad_dc;
    logic [7:0] a;
    logic [7:0] e;
    mism = 0; bad_dc = 0; a = 0; e = 0;
    for (int p = 0; p < n; p++) begin
      if (cap_b[base+p] !== exp_byte(seed, n, fmt, sw, p)) begin
        if (mism == 0) begin a = cap_b[base+p]; e = exp_byte(seed, n, fmt, sw, p); end
        mism++;
      end
      if (cap_dc[base+p] !== dc) bad_dc++;
    end
    chk(mism == 0, req, "byte order", a, e);
    chk(bad_dc == 0, "R1", "dc flag mismatches", bad_dc, 0);
  endtask

  task automatic finish_xfer(input string req, input int base, input int seed, input int n,
                             input logic dc, input int fmt, input logic sw);
    int t;
    t = 0;
    while (!done_sts && t < 5000) begin @(negedge clk); t++; end
    chk(done_sts, "R9", "done set after last byte", done_sts, 1);
    repeat (2) @(negedge clk);
    chk(cap_n - base == n, "R1", "byte count", cap_n - base, n);
    compare(req, base, seed, n, dc, fmt, sw);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    @(negedge clk);
    chk(!done_sts, "R9", "done cleared", done_sts, 0);
  endtask

  task automatic simple_xfer(input string req, input int seed, input int n, input logic dc,
                             input int fmt, input logic sw, input logic [31:0] extra, input int bp);
    int base;
    bp_mode = bp;
    swap_en = sw;
    base = cap_n;
    load_xfer(seed, n, mk_desc(n, dc, fmt, 0, extra));
    finish_xfer(req, base, seed, n, dc, fmt, sw);
    bp_mode = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!out_valid, "R10", "reset out_valid", out_valid, 0);
    chk(fifo_level == 0, "R7", "reset level", fifo_level, 0);
    chk(thresh_sts, "R8", "reset threshold", thresh_sts, 1);
    chk(!ovf_sts && !done_sts, "R9", "reset sticky flags", {ovf_sts, done_sts}, 0);
    chk(!busy, "R11", "reset idle", busy, 0);
  endtask

  task automatic t_formats;
    simple_xfer("R1", 1, 1, 1'b0, 0, 1'b0, 32'h0, 0);
    simple_xfer("R3", 2, 9, 1'b1, 0, 1'b1, 32'h0, 0);
    simple_xfer("R3", 3, 6, 1'b1, 3, 1'b1, 32'h0, 0);
    simple_xfer("R3", 4, 8, 1'b1, 1, 1'b0, 32'h0, 1);
    simple_xfer("R4", 5, 11, 1'b1, 1, 1'b1, 32'h0, 1);
    simple_xfer("R4", 6, 14, 1'b1, 2, 1'b1, 32'h0, 1);
    simple_xfer("R2", 7, 64, 1'b1, 2, 1'b1, 32'h0, 0);
    simple_xfer("R2", 8, 23, 1'b0, 2, 1'b0, 32'h0, 1);
  endtask

  task automatic t_ignored;
    simple_xfer("R6", 9, 7, 1'b1, 1, 1'b1, 32'hA4FC_0000, 0);
    simple_xfer("R6", 10, 5, 1'b0, 2, 1'b1, 32'h24FC_0000, 1);
  endtask

  task automatic t_back_to_back;
    int base;
    int t;
    swap_en = 1'b0;
    base = cap_n;
    load_xfer(11, 3, mk_desc(3, 1'b0, 0, 0, 32'h0));
    load_xfer(12, 5, mk_desc(5, 1'b1, 0, 0, 32'h0));
    t = 0;
    while ((cap_n - base) < 8 && t < 3000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk(cap_n - base == 8, "R12", "two transfers byte count", cap_n - base, 8);
    compare("R12", base, 11, 3, 1'b0, 0, 1'b0);
    compare("R12", base + 3, 12, 5, 1'b1, 0, 1'b0);
    done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
  endtask

  task automatic t_tearing;
    int base;
    int seen;
    swap_en = 1'b0;
    te_in = 1'b0;
    repeat (5) @(negedge clk);
    base = cap_n;
    load_xfer(13, 8, mk_desc(8, 1'b1, 0, 1, 32'h0));
    seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (out_valid) seen++; end
    chk(seen == 0, "R5", "no output before rising edge", seen, 0);
    te_in = 1'b1;
    finish_xfer("R5", base, 13, 8, 1'b1, 0, 1'b0);
    te_in = 1'b0;
    repeat (6) @(negedge clk);
    base = cap_n;
    load_xfer(14, 6, mk_desc(6, 1'b1, 0, 2, 32'h0));
    repeat (5) @(negedge clk);
    te_in = 1'b1;
    seen = 0;
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (out_valid) seen++; end
    chk(seen == 0, "R5", "rising edge ignored in falling mode", seen, 0);
    te_in = 1'b0;
    finish_xfer("R5", base, 14, 6, 1'b1, 0, 1'b0);
  endtask

  task automatic t_overflow;
    bp_mode = 2;
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    push_word(mk_desc(100, 1'b1, 0, 0, 32'h0));
    push_word(32'h0403_0201);
    repeat (6) @(negedge clk);
    chk(fifo_level == 0 && out_valid, "R10", "engine stalled, fifo drained", fifo_level, 0);
    for (int i = 0; i < 3; i++) raw_write(32'h1111_0000 + i);
    chk(thresh_sts, "R8", "level 3 at threshold", thresh_sts, 1);
    raw_write(32'h2222_2222);
    chk(!thresh_sts, "R8", "level 4 above threshold", thresh_sts, 0);
    for (int i = 0; i < 4; i++) raw_write(32'h3333_0000 + i);
    chk(fifo_level == DEPTH && !ovf_sts, "R7", "full without overflow", ovf_sts, 0);
    raw_write(32'h4444_4444);
    chk(ovf_sts, "R7", "overflow set", ovf_sts, 1);
    chk(fifo_level == DEPTH, "R7", "dropped write level", fifo_level, DEPTH);
    @(negedge clk);
    chk(ovf_sts, "R7", "overflow sticky", ovf_sts, 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk(!ovf_sts, "R7", "overflow cleared", ovf_sts, 0);
    enable = 1'b0;
    @(negedge clk);
    chk(fifo_level == 0 && !out_valid && !busy, "R11", "flush on disable", fifo_level, 0);
    raw_write(32'h5555_5555);
    chk(fifo_level == 0, "R11", "write ignored while disabled", fifo_level, 0);
    chk(!done_sts, "R11", "no done on abort", done_sts, 0);
    enable = 1'b1;
    bp_mode = 0;
    @(negedge clk);
    simple_xfer("R11", 15, 10, 1'b1, 1, 1'b1, 32'h0, 0);
  endtask

  task automatic t_abort;
    int t;
    bp_mode = 1;
    swap_en = 1'b0;
    t = cap_n;
    load_xfer(16, 40, mk_desc(40, 1'b1, 0, 0, 32'h0));
    while ((cap_n - t) < 5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(!out_valid && !busy && fifo_level == 0, "R11", "abort mid transfer", busy, 0);
    enable = 1'b1;
    bp_mode = 0;
    @(negedge clk);
    simple_xfer("R11", 17, 13, 1'b0, 2, 1'b1, 32'h0, 0);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b1; swap_en = 1'b0; wr_valid = 1'b0; wr_data = '0;
    ovf_clr = 1'b0; done_clr = 1'b0; te_in = 1'b0; thresh_lvl = LVL_W'(3);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_formats();
    t_ignored();
    t_back_to_back();
    t_tearing();
    t_overflow();
    t_abort();
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule